// File: doc/BRIEF.md
# Reloadable Multi-Mode Timer Channel

This block is a single channel of a general-purpose down/up counter with a reload register. A two-bit mode input selects how the one counter behaves. It can run as a periodic timer, optionally gated by an input pin. It can count pin edges up or down, either as plain pulses or as a two-phase quadrature pair. It can produce a single output pulse when a trigger arrives. It can also produce a retriggerable pulse whose high time equals the reload value.

The count clock-enable is picked from a vector of prescaled strobes. Start triggers come from the channel's own pin, from a designated other timer, or from the previous or next channel in a ring. The counter wraps to the reload value on underflow or overflow, which also fires a one-cycle strobe. The output pin shows either that strobe (or the active window) or a toggle flip-flop, with an optional inversion. Register access is reduced to a reload write port and static configuration inputs. All pin inputs are taken to be synchronous to `clk` already.

Top module: `mrt_channel`

## Requirements
- R1: Mode encoding: `cfg_mode` 2'b00 timer, 2'b01 event counter, 2'b10 one-shot, 2'b11 pulse-width. After synchronous reset the count is 0, the reload value is 0, `ovf_strobe` is 0 and `pulse_out` equals `cfg_invert`.
- R2: In timer mode with `start`=1 the count drops by one on every cycle where the selected clock-enable is high. When `cfg_gate_en`=1 it counts only while `pin_in` is 1.
- R3: In timer and event modes, a decrement step taken at count 0 loads the reload value and raises `ovf_strobe` for exactly one cycle. In event mode an increment step taken at 16'hFFFF does the same.
- R4: A reload write stores `reload_wdata`. While `start`=0 it also loads the count. If a reload write lands in the same cycle as a wrap, the count takes the previous reload value.
- R5: In event mode (`cfg_quad`=0) the count steps once on each rising edge of `pin_in` and ignores the clock-enable. The direction is `cfg_count_up` (1 = up), or `pin_aux` when `cfg_dir_from_pin`=1.
- R6: In event mode with `cfg_quad`=1, `pin_in` is phase A and `pin_aux` is phase B. A change of exactly one phase steps the count. The sequence (A,B) 00→10→11→01→00 counts up and the reverse sequence counts down. A change of both phases at once is ignored. A rising edge of `pin_z` clears the count to 0.
- R7: In one-shot and pulse-width modes, `cfg_trig_sel` picks the trigger: 2'b00 rising edge of `pin_in`, 2'b01 `alt_ovf`, 2'b10 the ring overflow of the previous channel, 2'b11 that of the next channel. Neighbours wrap around `NCH` channels: channel 0's previous channel is `NCH-1`, and channel `NCH-1`'s next channel is 0.
- R8: In one-shot mode a trigger while idle loads the reload value and makes the output active. The count then drops on each clock-enable. The clock-enable taken at count 0 ends the pulse, raises `ovf_strobe` and reloads the count. The output is therefore active for reload+1 enabled cycles. Triggers while active are ignored.
- R9: In pulse-width mode every trigger, including one arriving while active, loads the reload value and makes the output high. The output goes low with a one-cycle `ovf_strobe` when the count reaches 0, so it is high for exactly the reload value of enabled cycles. A reload value of 0 produces no high time.
- R10: `cfg_toggle`=1 drives `pulse_out` from a flip-flop that flips on every wrap strobe. Otherwise the output is the direct pulse: the wrap strobe in timer and event modes, and the active window in one-shot and pulse-width modes. `cfg_invert`=1 inverts the result.
- R11: With `start`=0 the count holds (apart from R4 loads), any one-shot or pulse-width window is cancelled, and the toggle flip-flop is cleared.
- R12: The clock-enable used for counting is `tick_vec[clk_sel]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_vec | input | NSRC | Prescaled clock-enable candidates |
| clk_sel | input | $clog2(NSRC) | Index of the clock-enable used |
| start | input | 1 | Channel run enable |
| cfg_mode | input | 2 | Operating mode |
| cfg_gate_en | input | 1 | Timer mode: gate counting with `pin_in` |
| cfg_count_up | input | 1 | Event mode direction bit, 1 = up |
| cfg_dir_from_pin | input | 1 | Event mode: take direction from `pin_aux` |
| cfg_quad | input | 1 | Event mode: two-phase decoding |
| cfg_trig_sel | input | 2 | One-shot / pulse-width trigger source |
| cfg_toggle | input | 1 | Output from toggle flip-flop |
| cfg_invert | input | 1 | Invert output |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | CNT_W | Reload write data |
| pin_in | input | 1 | Gate, count, phase A or trigger pin |
| pin_aux | input | 1 | Direction or phase B pin |
| pin_z | input | 1 | Quadrature counter-clear pin |
| alt_ovf | input | 1 | Overflow strobe of a designated other timer |
| ring_ovf | input | NCH | Overflow strobes of all ring channels |
| count_q | output | CNT_W | Current count |
| ovf_strobe | output | 1 | One-cycle wrap strobe |
| pulse_out | output | 1 | Pulse output pin |

## Verification
Two functions can meet in one cycle: a reload write and the counter's own wrap. The bench arranges this by issuing the write at the exact cycle where a timer-mode count of 0 meets an enabled step. It then expects the count to take the old reload value and the strobe to fire in that cycle. It also counts down the next period to confirm that the new value is taken at the following wrap. A second case sends a pulse-width trigger while a window is still running and expects a full restart from the reload value instead of the next decrement.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    localparam int CNT_W_DEF = 16;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'b00,
        MODE_EVENT   = 2'b01,
        MODE_ONESHOT = 2'b10,
        MODE_PWM     = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        TRG_PIN  = 2'b00,
        TRG_ALT  = 2'b01,
        TRG_PREV = 2'b10,
        TRG_NEXT = 2'b11
    } trig_e;

    // Decoded count event from the input pins
    typedef struct packed {
        logic step;
        logic up;
        logic zclr;
    } evt_t;

    function automatic int ring_prev(input int idx, input int n);
        return (idx == 0) ? n - 1 : idx - 1;
    endfunction

    function automatic int ring_next(input int idx, input int n);
        return (idx == n - 1) ? 0 : idx + 1;
    endfunction

    // Quadrature direction: up when the old A phase equals the new B phase
    function automatic logic quad_dir_up(input logic a_old, input logic b_new);
        return ~(a_old ^ b_new);
    endfunction

endpackage

// File: rtl/mrt_sense.sv
module mrt_sense
    import mrt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic pin_aux,
    input  logic pin_z,
    input  logic quad_en,
    input  logic up_bit,
    input  logic dir_from_pin,
    output logic pin_rise,
    output evt_t evt
);

    logic a_q, b_q, z_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
            z_q <= 1'b0;
        end else begin
            a_q <= pin_in;
            b_q <= pin_aux;
            z_q <= pin_z;
        end
    end

    logic a_chg, b_chg;
    assign a_chg    = pin_in ^ a_q;
    assign b_chg    = pin_aux ^ b_q;
    assign pin_rise = pin_in & ~a_q;

    always_comb begin
        evt = '0;
        if (quad_en) begin
            evt.step = a_chg ^ b_chg;
            evt.up   = quad_dir_up(a_q, pin_aux);
            evt.zclr = pin_z & ~z_q;
        end else begin
            evt.step = pin_rise;
            evt.up   = dir_from_pin ? pin_aux : up_bit;
        end
    end

    // R6: a simultaneous change of both phases never produces a step
    p_quad_both_r6: assert property (@(posedge clk) disable iff (rst)
        (quad_en && a_chg && b_chg) |-> !evt.step);

endmodule

// File: rtl/mrt_trig.sv
module mrt_trig
    import mrt_pkg::*;
#(
    parameter int NCH    = 5,
    parameter int CH_IDX = 0
) (
    input  logic [1:0]     trig_sel,
    input  logic           pin_rise,
    input  logic           alt_ovf,
    input  logic [NCH-1:0] ring_ovf,
    output logic           trig
);

    localparam int PREV_IDX = ring_prev(CH_IDX, NCH);
    localparam int NEXT_IDX = ring_next(CH_IDX, NCH);

    logic prev_ovf, next_ovf;

    always_comb begin
        prev_ovf = 1'b0;
        next_ovf = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (i == PREV_IDX) prev_ovf = prev_ovf | ring_ovf[i];
            if (i == NEXT_IDX) next_ovf = next_ovf | ring_ovf[i];
        end
    end

    always_comb begin
        case (trig_e'(trig_sel))
            TRG_PIN:  trig = pin_rise;
            TRG_ALT:  trig = alt_ovf;
            TRG_PREV: trig = prev_ovf;
            TRG_NEXT: trig = next_ovf;
            default:  trig = 1'b0;
        endcase
    end

endmodule

// File: rtl/mrt_core.sv
module mrt_core
    import mrt_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  mode_e            mode,
    input  logic             gate_en,
    input  logic             gate_pin,
    input  logic             tick,
    input  evt_t             evt,
    input  logic             trig,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             act_q,
    output logic             ovf_q,
    output logic             ovf_d
);

    localparam logic [CNT_W-1:0] ZERO_V = '0;
    localparam logic [CNT_W-1:0] ONE_V  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] MAX_V  = '1;

    logic [CNT_W-1:0] rld_q;
    logic [CNT_W-1:0] cnt_d;
    logic             act_d;

    always_comb begin
        cnt_d = cnt_q;
        act_d = act_q;
        ovf_d = 1'b0;
        if (!start) begin
            act_d = 1'b0;
            if (reload_we) cnt_d = reload_wdata;
        end else begin
            case (mode)
                MODE_TIMER: begin
                    act_d = 1'b0;
                    if (tick && (!gate_en || gate_pin)) begin
                        if (cnt_q == ZERO_V) begin
                            cnt_d = rld_q;
                            ovf_d = 1'b1;
                        end else begin
                            cnt_d = cnt_q - ONE_V;
                        end
                    end
                end
                MODE_EVENT: begin
                    act_d = 1'b0;
                    if (evt.zclr) begin
                        cnt_d = ZERO_V;
                    end else if (evt.step) begin
                        if (evt.up) begin
                            if (cnt_q == MAX_V) begin
                                cnt_d = rld_q;
                                ovf_d = 1'b1;
                            end else begin
                                cnt_d = cnt_q + ONE_V;
                            end
                        end else begin
                            if (cnt_q == ZERO_V) begin
                                cnt_d = rld_q;
                                ovf_d = 1'b1;
                            end else begin
                                cnt_d = cnt_q - ONE_V;
                            end
                        end
                    end
                end
                MODE_ONESHOT: begin
                    if (!act_q) begin
                        if (trig) begin
                            cnt_d = rld_q;
                            act_d = 1'b1;
                        end
                    end else if (tick) begin
                        if (cnt_q == ZERO_V) begin
                            cnt_d = rld_q;
                            act_d = 1'b0;
                            ovf_d = 1'b1;
                        end else begin
                            cnt_d = cnt_q - ONE_V;
                        end
                    end
                end
                MODE_PWM: begin
                    if (trig) begin
                        cnt_d = rld_q;
                        act_d = (rld_q != ZERO_V);
                    end else if (act_q && tick) begin
                        if (cnt_q <= ONE_V) begin
                            cnt_d = ZERO_V;
                            act_d = 1'b0;
                            ovf_d = 1'b1;
                        end else begin
                            cnt_d = cnt_q - ONE_V;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_q <= ZERO_V;
            cnt_q <= ZERO_V;
            act_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (reload_we) rld_q <= reload_wdata;
            cnt_q <= cnt_d;
            act_q <= act_d;
            ovf_q <= ovf_d;
        end
    end

    // R3: a wrap outside pulse-width mode lands on the reload value held before the edge
    p_wrap_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && ($past(mode) != MODE_PWM)) |-> (cnt_q == $past(rld_q)));

    // R2: a running timer above zero moves by at most one per cycle
    p_timer_step_r2: assert property (@(posedge clk) disable iff (rst)
        (start && mode == MODE_TIMER && cnt_q != ZERO_V) |=>
        ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - ONE_V)));

    // R11: stopped channel holds its count and has no active window
    p_hold_stopped_r11: assert property (@(posedge clk) disable iff (rst)
        (!start && !reload_we) |=> ($stable(cnt_q) && !act_q));

    // R8: an active one-shot above zero stays active whatever triggers arrive
    p_oneshot_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (start && mode == MODE_ONESHOT && act_q && cnt_q != ZERO_V) |=> act_q);

    // R9: a pulse-width strobe marks the end of the high window at count zero
    p_pwm_end_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && ($past(mode) == MODE_PWM)) |-> (!act_q && cnt_q == ZERO_V));

endmodule

// File: rtl/mrt_out.sv
module mrt_out
    import mrt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  mode_e mode,
    input  logic  toggle_en,
    input  logic  invert,
    input  logic  ovf_d,
    input  logic  ovf_q,
    input  logic  act_q,
    output logic  pulse_out
);

    logic tff_q;
    logic direct;

    always_ff @(posedge clk) begin
        if (rst)        tff_q <= 1'b0;
        else if (!start) tff_q <= 1'b0;
        else if (ovf_d)  tff_q <= ~tff_q;
    end

    always_comb begin
        direct    = (mode == MODE_ONESHOT || mode == MODE_PWM) ? act_q : ovf_q;
        pulse_out = (toggle_en ? tff_q : direct) ^ invert;
    end

    // R10: every wrap strobe flips the toggle flip-flop on a running channel
    p_tff_flip_r10: assert property (@(posedge clk) disable iff (rst)
        (start && ovf_d) |=> (tff_q != $past(tff_q)));

endmodule

// File: rtl/mrt_channel.sv
module mrt_channel
    import mrt_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int NSRC   = 4,
    parameter int NCH    = 5,
    parameter int CH_IDX = 0,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  tick_vec,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             start,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_gate_en,
    input  logic             cfg_count_up,
    input  logic             cfg_dir_from_pin,
    input  logic             cfg_quad,
    input  logic [1:0]       cfg_trig_sel,
    input  logic             cfg_toggle,
    input  logic             cfg_invert,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             pin_in,
    input  logic             pin_aux,
    input  logic             pin_z,
    input  logic             alt_ovf,
    input  logic [NCH-1:0]   ring_ovf,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf_strobe,
    output logic             pulse_out
);

    mode_e mode;
    logic  tick;
    logic  pin_rise;
    evt_t  evt;
    logic  trig;
    logic  act_q;
    logic  ovf_q;
    logic  ovf_d;

    assign mode = mode_e'(cfg_mode);
    assign tick = tick_vec[clk_sel];

    mrt_sense u_sense (
        .clk          (clk),
        .rst          (rst),
        .pin_in       (pin_in),
        .pin_aux      (pin_aux),
        .pin_z        (pin_z),
        .quad_en      (cfg_quad),
        .up_bit       (cfg_count_up),
        .dir_from_pin (cfg_dir_from_pin),
        .pin_rise     (pin_rise),
        .evt          (evt)
    );

    mrt_trig #(
        .NCH    (NCH),
        .CH_IDX (CH_IDX)
    ) u_trig (
        .trig_sel (cfg_trig_sel),
        .pin_rise (pin_rise),
        .alt_ovf  (alt_ovf),
        .ring_ovf (ring_ovf),
        .trig     (trig)
    );

    mrt_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .mode         (mode),
        .gate_en      (cfg_gate_en),
        .gate_pin     (pin_in),
        .tick         (tick),
        .evt          (evt),
        .trig         (trig),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .cnt_q        (count_q),
        .act_q        (act_q),
        .ovf_q        (ovf_q),
        .ovf_d        (ovf_d)
    );

    mrt_out u_out (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .toggle_en (cfg_toggle),
        .invert    (cfg_invert),
        .ovf_d     (ovf_d),
        .ovf_q     (ovf_q),
        .act_q     (act_q),
        .pulse_out (pulse_out)
    );

    assign ovf_strobe = ovf_q;

endmodule

// File: tb/mrt_channel_tb_top.sv
`timescale 1ns/1ps
module mrt_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  tick_vec = 4'b1111;
    logic [1:0]  clk_sel = 2'd0;
    logic        start = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        cfg_gate_en = 1'b0;
    logic        cfg_count_up = 1'b0;
    logic        cfg_dir_from_pin = 1'b0;
    logic        cfg_quad = 1'b0;
    logic [1:0]  cfg_trig_sel = 2'b00;
    logic        cfg_toggle = 1'b0;
    logic        cfg_invert = 1'b0;
    logic        reload_we = 1'b0;
    logic [15:0] reload_wdata = 16'h0;
    logic        pin_in = 1'b0;
    logic        pin_aux = 1'b0;
    logic        pin_z = 1'b0;
    logic        alt_ovf = 1'b0;
    logic [4:0]  ring_ovf = 5'b0;
    logic [15:0] count_q;
    logic        ovf_strobe;
    logic        pulse_out;

    always #4 clk = ~clk;

    mrt_channel dut_i (
        .clk(clk), .rst(rst), .tick_vec(tick_vec), .clk_sel(clk_sel), .start(start),
        .cfg_mode(cfg_mode), .cfg_gate_en(cfg_gate_en), .cfg_count_up(cfg_count_up),
        .cfg_dir_from_pin(cfg_dir_from_pin), .cfg_quad(cfg_quad), .cfg_trig_sel(cfg_trig_sel),
        .cfg_toggle(cfg_toggle), .cfg_invert(cfg_invert), .reload_we(reload_we),
        .reload_wdata(reload_wdata), .pin_in(pin_in), .pin_aux(pin_aux), .pin_z(pin_z),
        .alt_ovf(alt_ovf), .ring_ovf(ring_ovf), .count_q(count_q), .ovf_strobe(ovf_strobe),
        .pulse_out(pulse_out)
    );

    typedef struct {
        logic [15:0] cnt;
        logic        ovf;
        logic        out;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // Monitor: pops expected items and compares after each edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_chk++;
                if (count_q !== e.cnt || ovf_strobe !== e.ovf || pulse_out !== e.out) begin
                    n_fail++;
                    $display("FAIL %s: got cnt=%h ovf=%b out=%b, expected cnt=%h ovf=%b out=%b",
                             e.tag, count_q, ovf_strobe, pulse_out, e.cnt, e.ovf, e.out);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // Driver: push one expectation for the current cycle, let the monitor take it
    task automatic expect_now(input logic [15:0] c, input logic o, input logic p, input string tag);
        exp_t e;
        e.cnt = c; e.ovf = o; e.out = p; e.tag = tag;
        sb_q.push_back(e);
        #2;
    endtask

    task automatic step_chk(input logic [15:0] c, input logic o, input logic p, input string tag);
        cyc();
        expect_now(c, o, p, tag);
    endtask

    task automatic load_stopped(input logic [15:0] v);
        start = 1'b0; reload_we = 1'b1; reload_wdata = v;
        cyc();
        reload_we = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        expect_now(16'h0, 1'b0, 1'b0, "R1 reset state");
        rst = 1'b0;
        cyc();

        // Timer mode
        start = 1'b0; reload_we = 1'b1; reload_wdata = 16'd3;
        step_chk(16'd3, 0, 0, "R4 load while stopped");
        reload_we = 1'b0; cfg_mode = 2'b00; start = 1'b1;
        step_chk(16'd2, 0, 0, "R2 timer decrement");
        cyc();
        step_chk(16'd0, 0, 0, "R2 timer reaches zero");
        step_chk(16'd3, 1, 1, "R3 underflow reload and strobe");
        step_chk(16'd2, 0, 0, "R3 strobe lasts one cycle");

        // Gate
        cfg_gate_en = 1'b1; pin_in = 1'b0;
        cyc(); cyc();
        step_chk(16'd2, 0, 0, "R2 gate low holds");
        pin_in = 1'b1;
        step_chk(16'd1, 0, 0, "R2 gate high counts");
        cfg_gate_en = 1'b0; pin_in = 1'b0;

        // Clock-enable select
        tick_vec = 4'b0100; clk_sel = 2'd0;
        cyc();
        step_chk(16'd1, 0, 0, "R12 unselected enable ignored");
        clk_sel = 2'd2;
        step_chk(16'd0, 0, 0, "R12 selected enable counts");
        tick_vec = 4'b1111; clk_sel = 2'd0;

        // Reload write colliding with underflow
        reload_we = 1'b1; reload_wdata = 16'd7;
        step_chk(16'd3, 1, 1, "R4 collision takes old reload");
        reload_we = 1'b0;
        cyc(); cyc(); cyc();
        step_chk(16'd7, 1, 1, "R4 new reload used next wrap");

        // Stop, toggle and invert
        start = 1'b0; cfg_toggle = 1'b1;
        cyc();
        step_chk(16'd7, 0, 0, "R11 stopped holds, toggle cleared");
        cfg_invert = 1'b1;
        step_chk(16'd7, 0, 1, "R10 invert");
        cfg_invert = 1'b0; reload_we = 1'b1; reload_wdata = 16'd1;
        step_chk(16'd1, 0, 0, "R4 stopped load");
        reload_we = 1'b0; start = 1'b1;
        step_chk(16'd0, 0, 0, "R10 toggle before wrap");
        step_chk(16'd1, 1, 1, "R10 toggle flips on wrap");
        step_chk(16'd0, 0, 1, "R10 toggle holds");
        step_chk(16'd1, 1, 0, "R10 toggle flips back");
        cfg_toggle = 1'b0;

        // Event counter
        load_stopped(16'd5);
        cfg_mode = 2'b01; cfg_count_up = 1'b1; start = 1'b1;
        pin_in = 1'b1;
        step_chk(16'd6, 0, 0, "R5 rising edge counts up");
        step_chk(16'd6, 0, 0, "R5 level and ticks ignored");
        pin_in = 1'b0; cyc();
        pin_in = 1'b1;
        step_chk(16'd7, 0, 0, "R5 second edge");
        pin_in = 1'b0; cyc();

        load_stopped(16'hFFFE);
        start = 1'b1;
        pin_in = 1'b1;
        step_chk(16'hFFFF, 0, 0, "R5 up to max");
        pin_in = 1'b0; cyc();
        pin_in = 1'b1;
        step_chk(16'hFFFE, 1, 1, "R3 overflow past max reloads");
        pin_in = 1'b0; cyc();

        cfg_dir_from_pin = 1'b1; pin_aux = 1'b0;
        pin_in = 1'b1;
        step_chk(16'hFFFD, 0, 0, "R5 direction pin low counts down");
        pin_in = 1'b0; cyc();
        pin_aux = 1'b1;
        pin_in = 1'b1;
        step_chk(16'hFFFE, 0, 0, "R5 direction pin high counts up");
        pin_in = 1'b0; cyc();

        // Quadrature, phases now A=0 B=1
        cfg_dir_from_pin = 1'b0; cfg_count_up = 1'b0; cfg_quad = 1'b1;
        pin_in = 1'b0; pin_aux = 1'b0;
        step_chk(16'hFFFF, 0, 0, "R6 01->00 up");
        pin_in = 1'b1; pin_aux = 1'b0;
        step_chk(16'hFFFE, 1, 1, "R6 00->10 up wraps");
        pin_in = 1'b1; pin_aux = 1'b1;
        step_chk(16'hFFFF, 0, 0, "R6 10->11 up");
        pin_in = 1'b1; pin_aux = 1'b0;
        step_chk(16'hFFFE, 0, 0, "R6 11->10 down");
        pin_in = 1'b0; pin_aux = 1'b1;
        step_chk(16'hFFFE, 0, 0, "R6 both phases ignored");
        pin_z = 1'b1;
        step_chk(16'h0000, 0, 0, "R6 z edge clears");
        step_chk(16'h0000, 0, 0, "R6 z level holds");
        pin_z = 1'b0; cfg_quad = 1'b0; pin_in = 1'b0; pin_aux = 1'b0;
        cyc();

        // One-shot
        cfg_mode = 2'b10; cfg_trig_sel = 2'b00;
        load_stopped(16'd2);
        start = 1'b1;
        step_chk(16'd2, 0, 0, "R8 idle ignores ticks");
        pin_in = 1'b1;
        step_chk(16'd2, 0, 1, "R7 pin trigger starts");
        pin_in = 1'b0;
        step_chk(16'd1, 0, 1, "R8 active counting");
        pin_in = 1'b1;
        step_chk(16'd0, 0, 1, "R8 retrigger ignored");
        pin_in = 1'b0;
        step_chk(16'd2, 1, 0, "R8 underflow ends pulse");

        cfg_trig_sel = 2'b01; alt_ovf = 1'b1;
        step_chk(16'd2, 0, 1, "R7 alt overflow trigger");
        alt_ovf = 1'b0;
        cyc(); cyc();
        step_chk(16'd2, 1, 0, "R8 alt pulse ends");

        cfg_trig_sel = 2'b10; ring_ovf = 5'b00010;
        step_chk(16'd2, 0, 0, "R7 next ignored when previous selected");
        ring_ovf = 5'b10000;
        step_chk(16'd2, 0, 1, "R7 previous of channel 0 is channel 4");
        ring_ovf = 5'b0;
        cyc(); cyc();
        step_chk(16'd2, 1, 0, "R8 ring pulse ends");

        cfg_trig_sel = 2'b11; ring_ovf = 5'b10000;
        step_chk(16'd2, 0, 0, "R7 previous ignored when next selected");
        ring_ovf = 5'b00010;
        step_chk(16'd2, 0, 1, "R7 next channel trigger");
        ring_ovf = 5'b0;
        cyc(); cyc();
        step_chk(16'd2, 1, 0, "R8 next pulse ends");

        // Pulse-width
        cfg_mode = 2'b11; cfg_trig_sel = 2'b00;
        load_stopped(16'd3);
        start = 1'b1;
        pin_in = 1'b1;
        step_chk(16'd3, 0, 1, "R9 trigger high");
        pin_in = 1'b0;
        step_chk(16'd2, 0, 1, "R9 high edge 2");
        step_chk(16'd1, 0, 1, "R9 high edge 3");
        step_chk(16'd0, 1, 0, "R9 low after reload count");
        step_chk(16'd0, 0, 0, "R9 stays low");
        pin_in = 1'b1;
        step_chk(16'd3, 0, 1, "R9 second period");
        pin_in = 1'b0;
        step_chk(16'd2, 0, 1, "R9 second period count");
        pin_in = 1'b1;
        step_chk(16'd3, 0, 1, "R9 retrigger restarts");
        pin_in = 1'b0;
        step_chk(16'd2, 0, 1, "R9 after restart");
        step_chk(16'd1, 0, 1, "R9 after restart 2");
        step_chk(16'd0, 1, 0, "R9 restarted period ends");
        pin_in = 1'b1;
        step_chk(16'd3, 0, 1, "R9 trigger before cancel");
        pin_in = 1'b0; start = 1'b0;
        step_chk(16'd3, 0, 0, "R11 stop cancels window");
        load_stopped(16'd0);
        start = 1'b1; pin_in = 1'b1;
        step_chk(16'd0, 0, 0, "R9 zero reload no high time");
        pin_in = 1'b0;
        cyc();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule